// File: doc/BRIEF.md
# Quarter-Rate Quadrature Upconverter

This block moves a complex baseband signal up to an intermediate frequency of exactly one quarter of the sample clock. At that frequency the cosine carrier takes only the values +1, 0, -1, 0 and the sine carrier is the same sequence shifted by one clock. Mixing therefore needs no multiplier and no oscillator. Each output sample is one of the two baseband components, either as it is or negated, chosen by a free-running two-bit phase count. The in-phase and quadrature products are combined into one real signed stream per clock, which feeds a bandpass noise shaper whose notch sits at the same quarter-rate frequency.

Baseband pairs arrive at a lower rate than the sample clock. A pair presented with its valid strobe is captured into a staging register. The active pair is replaced only at the start of each hold period of `RATIO` sample clocks, and it is held (zero-order) until a newer pair arrives. The output is one bit wider than the input, so negating the most negative input code cannot wrap.

Top module: `qrate_iq_upmix`

## Requirements
- R1: A synchronous active-high reset clears the output to 0, the phase count to 0, the active pair to (0, 0) and any pending staged pair. After reset is released with no input, the output stays 0.
- R2: The output is `SAMPLE_W+1` bits in two's complement. Negating the input code -2^(SAMPLE_W-1) gives +2^(SAMPLE_W-1) with no wrap.
- R3: The phase count steps 0,1,2,3 and repeats every clock. The output for phase 0, 1, 2, 3 is +I, -Q, -I, +Q of the active pair.
- R4: The output is registered. The value present after a clock edge is computed from the phase count and the active pair held just before that edge, so after reset the first edge produces the phase 0 value.
- R5: A clock edge with `in_valid` high writes `in_i`/`in_q` into the staging register. When several pairs arrive within one hold period, the last one is used.
- R6: The active pair changes only on a period boundary. With `RATIO`=4, that is the 1st, 5th, 9th, ... edge after reset release. It takes the staged pair only if one arrived since the previous boundary. A pair that arrives in the middle of a period has no effect on the output until the boundary edge has passed.
- R7: Without new input, the active pair is reused indefinitely and the four-value output cycle repeats unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: `in_i`/`in_q` hold a new baseband pair |
| in_i | input | SAMPLE_W | In-phase baseband sample, signed |
| in_q | input | SAMPLE_W | Quadrature baseband sample, signed |
| out_sample | output | SAMPLE_W+1 | Upconverted real sample, signed |

## Verification
The hardest case to reach from the ports is a pair that arrives in the middle of a hold period. Its effect is invisible for several clocks and then appears exactly one edge after the boundary, at a phase other than 0. The stimulus counts edges from reset release so that pairs land at known offsets inside the period. It checks the last outputs of the old pair and the first output of the new one, including a case where two pairs arrive in one period. The extreme codes on both components exercise the widened negation.

// File: rtl/qru_pkg.sv
package qru_pkg;

    typedef enum logic [1:0] {
        PH_COS_POS = 2'd0,
        PH_SIN_NEG = 2'd1,
        PH_COS_NEG = 2'd2,
        PH_SIN_POS = 2'd3
    } phase_e;

    typedef struct packed {
        logic use_q;
        logic negate;
    } mix_ctl_t;

    function automatic phase_e phase_next(phase_e ph);
        return phase_e'(2'(ph) + 2'd1);
    endfunction

    function automatic mix_ctl_t ctl_of(phase_e ph);
        mix_ctl_t c;
        case (ph)
            PH_COS_POS: c = '{use_q: 1'b0, negate: 1'b0};
            PH_SIN_NEG: c = '{use_q: 1'b1, negate: 1'b1};
            PH_COS_NEG: c = '{use_q: 1'b0, negate: 1'b1};
            default:    c = '{use_q: 1'b1, negate: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/qru_phase_gen.sv
module qru_phase_gen
    import qru_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_COS_POS;
        end else begin
            phase <= phase_next(phase);
        end
    end

endmodule

// File: rtl/qru_rate_hold.sv
module qru_rate_hold #(
    parameter int SAMPLE_W = 12,
    parameter int RATIO    = 4,
    localparam int CNT_W   = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic [SAMPLE_W-1:0] held_i,
    output logic [SAMPLE_W-1:0] held_q,
    output logic [CNT_W-1:0]    slot_cnt,
    output logic                pending
);

    logic [SAMPLE_W-1:0] stage_i;
    logic [SAMPLE_W-1:0] stage_q;
    logic                boundary;

    generate
        if (RATIO > 1) begin : g_counter
            localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_cnt <= '0;
                end else if (slot_cnt == LAST) begin
                    slot_cnt <= '0;
                end else begin
                    slot_cnt <= slot_cnt + 1'b1;
                end
            end
            assign boundary = (slot_cnt == '0);
        end else begin : g_every_clock
            assign slot_cnt = '0;
            assign boundary = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_i <= '0;
            stage_q <= '0;
            pending <= 1'b0;
        end else begin
            if (in_valid) begin
                stage_i <= in_i;
                stage_q <= in_q;
                pending <= 1'b1;
            end else if (boundary) begin
                pending <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_i <= '0;
            held_q <= '0;
        end else if (boundary && pending) begin
            held_i <= stage_i;
            held_q <= stage_q;
        end
    end

endmodule

// File: rtl/qru_quad_mix.sv
module qru_quad_mix
    import qru_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    localparam int OUT_W   = SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  phase_e              phase,
    input  logic [SAMPLE_W-1:0] held_i,
    input  logic [SAMPLE_W-1:0] held_q,
    output logic [OUT_W-1:0]    mixed
);

    mix_ctl_t                   ctl;
    logic [SAMPLE_W-1:0]        picked;
    logic signed [OUT_W-1:0]    widened;
    logic signed [OUT_W-1:0]    signed_val;

    always_comb begin
        ctl        = ctl_of(phase);
        picked     = ctl.use_q ? held_q : held_i;
        widened    = {picked[SAMPLE_W-1], picked};
        signed_val = ctl.negate ? -widened : widened;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mixed <= '0;
        end else begin
            mixed <= signed_val;
        end
    end

endmodule

// File: rtl/qrate_iq_upmix.sv
module qrate_iq_upmix
    import qru_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int RATIO    = 4,
    localparam int OUT_W   = SAMPLE_W + 1,
    localparam int CNT_W   = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic [OUT_W-1:0]    out_sample
);

    phase_e              phase;
    logic [SAMPLE_W-1:0] held_i;
    logic [SAMPLE_W-1:0] held_q;
    logic [CNT_W-1:0]    slot_cnt;
    logic                pending;

    qru_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    qru_rate_hold #(
        .SAMPLE_W (SAMPLE_W),
        .RATIO    (RATIO)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .held_i   (held_i),
        .held_q   (held_q),
        .slot_cnt (slot_cnt),
        .pending  (pending)
    );

    qru_quad_mix #(
        .SAMPLE_W (SAMPLE_W)
    ) u_mix (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .held_i (held_i),
        .held_q (held_q),
        .mixed  (out_sample)
    );

endmodule

// File: rtl/qru_checker.sv
module qru_checker #(
    parameter int SAMPLE_W = 12,
    parameter int RATIO    = 4,
    localparam int OUT_W   = SAMPLE_W + 1,
    localparam int CNT_W   = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          phase,
    input logic [SAMPLE_W-1:0] held_i,
    input logic [SAMPLE_W-1:0] held_q,
    input logic [CNT_W-1:0]    slot_cnt,
    input logic                pending,
    input logic [OUT_W-1:0]    out_sample
);

    localparam int LIM = 2 ** (SAMPLE_W - 1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (out_sample == '0 && phase == 2'd0 && !pending)) // R1
        else $error("reset did not clear state");

    AST_OUTPUT_RANGE: assert property (@(posedge clk) disable iff (rst)
        ($signed(out_sample) <= LIM) && ($signed(out_sample) >= -LIM)) // R2
        else $error("output outside widened range");

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (phase == 2'($past(phase) + 2'd1))) // R3
        else $error("phase did not advance by one");

    AST_COS_POS: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0) |=> ($signed(out_sample) == $signed($past(held_i)))) // R4
        else $error("phase 0 output is not +I of prior pair");

    AST_COS_NEG: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2) |=> (OUT_W'($signed(out_sample) + $signed($past(held_i))) == '0)) // R2
        else $error("phase 2 output is not -I of prior pair");

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
        (slot_cnt != '0) |=> ($stable(held_i) && $stable(held_q))) // R6
        else $error("active pair changed inside a hold period");

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(slot_cnt) < RATIO)) // R6
        else $error("slot counter out of range");

endmodule

bind qrate_iq_upmix qru_checker #(
    .SAMPLE_W (SAMPLE_W),
    .RATIO    (RATIO)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .held_i     (held_i),
    .held_q     (held_q),
    .slot_cnt   (slot_cnt),
    .pending    (pending),
    .out_sample (out_sample)
);

// File: tb/qrate_iq_upmix_test.sv
`timescale 1ns/1ps
module qrate_iq_upmix_test;

    localparam int SW    = 12;
    localparam int RATIO = 4;
    localparam int VEC_N = 6;

    // stimulus: in-phase, quadrature
    localparam int VI [VEC_N] = '{100, -2048, 2047, 0, -1, 1234};
    localparam int VQ [VEC_N] = '{-50, 2047, -2048, 0, 1, -777};
    // expected outputs at phases 1,2,3,0: -Q, -I, +Q, +I
    localparam int VE [VEC_N][4] = '{
        '{50, -100, -50, 100},
        '{-2047, 2048, 2047, -2048},
        '{2048, -2047, -2048, 2047},
        '{0, 0, 0, 0},
        '{-1, 1, 1, -1},
        '{777, -1234, -777, 1234}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_i = '0;
    logic [SW-1:0] in_q = '0;
    logic [SW:0]   out_sample;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    qrate_iq_upmix #(.SAMPLE_W(SW), .RATIO(RATIO)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_i       (in_i),
        .in_q       (in_q),
        .out_sample (out_sample)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int exp);
        int act;
        act = int'($signed(out_sample));
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: out_sample actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(int vi, int vq);
        in_valid = 1'b1;
        in_i = SW'(vi);
        in_q = SW'(vq);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a_i, a_q, b_i, b_q, d_i, d_q;
        @(negedge clk);
        for (int k = 0; k < VEC_N; k++) begin
            rst = 1'b1;
            in_valid = 1'b0;
            step();
            check("R1 reset clears output", 0);
            rst = 1'b0;
            drive(VI[k], VQ[k]);
            step();                          // edge 1: staged, boundary without pending
            check("R4 first edge gives phase 0 of cleared pair", 0);
            in_valid = 1'b0;
            for (int e = 2; e <= 5; e++) begin
                step();                      // edge 5 loads the pair at the boundary
                check("R6 pair not active before boundary", 0);
            end
            step(); check("R3 phase 1 -Q", VE[k][0]);
            step(); check("R2 R3 phase 2 -I", VE[k][1]);
            step(); check("R3 phase 3 +Q", VE[k][2]);
            step(); check("R3 phase 0 +I", VE[k][3]);
        end

        // continue after edge 9 of last vector: active pair A
        a_i = VI[VEC_N-1]; a_q = VQ[VEC_N-1];
        b_i = -300; b_q = 411;
        d_i = 55;   d_q = -66;
        step(); check("R7 held pair repeats -Q", a_q * -1);       // edge 10
        drive(b_i, b_q);
        step(); check("R7 held pair -I", -a_i);                  // edge 11, B staged
        in_valid = 1'b0;
        step(); check("R6 mid-period pair not visible", a_q);    // edge 12
        step(); check("R6 boundary edge still old pair", a_i);   // edge 13, B loaded
        step(); check("R6 new pair after boundary", -b_q);       // edge 14
        drive(-999, 888);
        step(); check("R6 phase 2 of B", -b_i);                  // edge 15, C staged
        drive(d_i, d_q);
        step(); check("R6 phase 3 of B", b_q);                   // edge 16, D staged
        in_valid = 1'b0;
        step(); check("R6 boundary edge phase 0 of B", b_i);     // edge 17, D loaded
        step(); check("R5 last staged pair wins -Q", -d_q);      // edge 18
        step(); check("R5 last staged pair wins -I", -d_i);      // edge 19

        // reset in the middle of a run
        rst = 1'b1;
        step(); check("R1 mid-run reset clears output", 0);
        rst = 1'b0;
        for (int e = 0; e < 8; e++) begin
            step();
            check("R1 cleared pair gives zero output", 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule